// File: doc/BRIEF.md
# Transaction Qualifier for Event Counting

This block decides, one transaction at a time, whether that transaction may be counted by an event counter. Each transaction arrives with a source identifier, a target identifier and a trace-tag bit. Three independent checks are applied: the target identifier must lie inside an inclusive window, the source identifier must match a compare value on every bit not excluded by a mask, and the trace-tag bit must be set. Each check has its own enable bit in a shared control word, and all three sit under one master filter enable. When the master enable is off, every transaction is counted.

The control word and the two identifier setup words are plain inputs that hold configuration. The transaction side is a stream with a valid strobe and no ready: the filter never stalls and accepts one transaction in every cycle in which `txn_valid` is high, so no back-pressure reaches upstream. The result is registered once. It appears as `q_valid` and `q_count` in the cycle after the transaction, so it lines up with registered event strobes that the counters AND with `q_count`.

Top module: `txn_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `q_valid` and `q_count` are 0.
- R2: When control bit 1 (master enable) is 0, every valid transaction gives `q_count` = 1, whatever the other control bits and the identifier words hold.
- R3: With the target check on (control bit 5), a transaction passes it when min ≤ target ≤ max. Min is target word bits [11:1] and max is target word bits [22:12]. Both bounds are included.
- R4: With the target check on, a range whose max is 0 or whose max is below min fails every transaction.
- R5: With the source check on (control bit 4), a transaction passes it when ((source XOR compare) AND NOT mask) is 0. Compare is source word bits [11:1] and mask is source word bits [22:12]. A mask bit of 1 excludes that bit from the compare.
- R6: With the trace-tag check on (control bit 2), only transactions whose `txn_tag` is 1 pass it.
- R7: With the master enable at 1, `q_count` is the AND of the enabled checks. A disabled check counts as passing.
- R8: `q_valid` equals `txn_valid` of the previous cycle, and `q_count` is 1 only when `q_valid` is 1.
- R9: With the master enable at 1, all three check enables at 0 and both identifier words at 0, every transaction passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Control word: bit 1 master, bit 2 trace-tag check, bit 4 source check, bit 5 target check |
| srcid_word | input | 32 | Source compare value in [11:1] and ignore mask in [22:12] |
| tgtid_word | input | 32 | Target window minimum in [11:1] and maximum in [22:12] |
| txn_valid | input | 1 | A transaction is present this cycle |
| txn_src | input | 11 | Source identifier of the transaction |
| txn_tgt | input | 11 | Target identifier of the transaction |
| txn_tag | input | 1 | Trace-tag bit of the transaction |
| q_valid | output | 1 | A qualifier result is present (one cycle after the transaction) |
| q_count | output | 1 | The transaction may be counted |

## Verification
The bench steps the target identifier across both window edges and one past each edge. A comparator that is strict where it should be inclusive, or off by one, then drops or adds a count. It tries windows with max 0, with max below min, and with max equal to min, which catches a filter that fails open on a bad range or rejects a one-entry window. Masked and unmasked bit mismatches on the source show whether the mask polarity is inverted. Random control words mixed with near-hits on every field show a filter that ORs the checks, ignores the master enable, or lets a disabled check veto the count. The bench also looks for a result that is off by one cycle.

// File: rtl/txn_filt_pkg.sv
package txn_filt_pkg;
  // decoded filter enables taken from the control word
  typedef struct packed {
    logic master;
    logic tag_en;
    logic src_en;
    logic tgt_en;
  } filt_ctrl_t;

  localparam int CTL_MASTER_BIT = 1;
  localparam int CTL_TAG_BIT    = 2;
  localparam int CTL_SRC_BIT    = 4;
  localparam int CTL_TGT_BIT    = 5;
  localparam int FIELD_LO_POS   = 1;
endpackage

// File: rtl/filt_tgt_range.sv
module filt_tgt_range #(
  parameter int ID_W = 11
) (
  input  logic [ID_W-1:0] lo_bound,
  input  logic [ID_W-1:0] hi_bound,
  input  logic [ID_W-1:0] id_in,
  output logic            pass_o
);
  logic window_ok;
  logic above_lo;
  logic below_hi;

  always_comb begin
    window_ok = (hi_bound != '0) && (hi_bound >= lo_bound);
    above_lo  = (id_in >= lo_bound);
    below_hi  = (id_in <= hi_bound);
    pass_o    = window_ok && above_lo && below_hi;
  end
endmodule

// File: rtl/filt_src_match.sv
module filt_src_match #(
  parameter int ID_W = 11
) (
  input  logic [ID_W-1:0] cmp_val,
  input  logic [ID_W-1:0] ign_mask,
  input  logic [ID_W-1:0] id_in,
  output logic            pass_o
);
  logic [ID_W-1:0] diff_bits;

  genvar b;
  generate
    for (b = 0; b < ID_W; b++) begin : g_bit
      assign diff_bits[b] = (id_in[b] ^ cmp_val[b]) & ~ign_mask[b];
    end
  endgenerate

  assign pass_o = (diff_bits == '0);
endmodule

// File: rtl/txn_filter.sv
module txn_filter
  import txn_filt_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctrl_word,
  input  logic [REG_W-1:0] srcid_word,
  input  logic [REG_W-1:0] tgtid_word,
  input  logic             txn_valid,
  input  logic [ID_W-1:0]  txn_src,
  input  logic [ID_W-1:0]  txn_tgt,
  input  logic             txn_tag,
  output logic             q_valid,
  output logic             q_count
);
  localparam int LO_MSB = FIELD_LO_POS + ID_W - 1;
  localparam int HI_LSB = LO_MSB + 1;
  localparam int HI_MSB = HI_LSB + ID_W - 1;

  filt_ctrl_t      ctl;
  logic [ID_W-1:0] tgt_min, tgt_max, src_cmp, src_msk;
  logic            tgt_pass, src_pass, tag_pass, all_pass;

  always_comb begin
    ctl.master = ctrl_word[CTL_MASTER_BIT];
    ctl.tag_en = ctrl_word[CTL_TAG_BIT];
    ctl.src_en = ctrl_word[CTL_SRC_BIT];
    ctl.tgt_en = ctrl_word[CTL_TGT_BIT];
  end

  assign tgt_min = tgtid_word[LO_MSB:FIELD_LO_POS];
  assign tgt_max = tgtid_word[HI_MSB:HI_LSB];
  assign src_cmp = srcid_word[LO_MSB:FIELD_LO_POS];
  assign src_msk = srcid_word[HI_MSB:HI_LSB];

  filt_tgt_range #(.ID_W(ID_W)) u_tgt (
    .lo_bound (tgt_min),
    .hi_bound (tgt_max),
    .id_in    (txn_tgt),
    .pass_o   (tgt_pass)
  );

  filt_src_match #(.ID_W(ID_W)) u_src (
    .cmp_val  (src_cmp),
    .ign_mask (src_msk),
    .id_in    (txn_src),
    .pass_o   (src_pass)
  );

  assign tag_pass = txn_tag;

  always_comb begin
    if (!ctl.master) begin
      all_pass = 1'b1;
    end else begin
      all_pass = (!ctl.tgt_en || tgt_pass) &&
                 (!ctl.src_en || src_pass) &&
                 (!ctl.tag_en || tag_pass);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_count <= 1'b0;
    end else begin
      q_valid <= txn_valid;
      q_count <= txn_valid && all_pass;
    end
  end

  AST_COUNT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    q_count |-> q_valid) else $error("count without valid"); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> q_valid) else $error("valid not forwarded"); // R8
  AST_MASTER_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !ctrl_word[CTL_MASTER_BIT]) |=> q_count) else $error("master off blocked"); // R2
  AST_ZERO_MAX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && ctrl_word[CTL_MASTER_BIT] && ctrl_word[CTL_TGT_BIT] &&
     (tgtid_word[HI_MSB:HI_LSB] == '0)) |=> !q_count) else $error("empty window passed"); // R4
  AST_TAG_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && ctrl_word[CTL_MASTER_BIT] && ctrl_word[CTL_TAG_BIT] && !txn_tag)
    |=> !q_count) else $error("untagged passed"); // R6
endmodule

// File: tb/sim_txn_filter.sv
module sim_txn_filter;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     ctrl_word = '0, srcid_word = '0, tgtid_word = '0;
  logic            txn_valid = 1'b0;
  logic [ID_W-1:0] txn_src = '0, txn_tgt = '0;
  logic            txn_tag = 1'b0;
  logic            q_valid, q_count;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_filter u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .srcid_word(srcid_word),
    .tgtid_word(tgtid_word), .txn_valid(txn_valid), .txn_src(txn_src),
    .txn_tgt(txn_tgt), .txn_tag(txn_tag), .q_valid(q_valid), .q_count(q_count)
  );

  function automatic logic [31:0] mk_ctl(bit m, bit tg, bit s, bit t);
    return (32'(m) << 1) | (32'(tg) << 2) | (32'(s) << 4) | (32'(t) << 5);
  endfunction

  function automatic logic [31:0] mk_pair(logic [ID_W-1:0] lo, logic [ID_W-1:0] hi);
    return (32'(lo) << 1) | (32'(hi) << 12);
  endfunction

  function automatic bit model(logic [31:0] c, logic [31:0] sw, logic [31:0] tw,
                               logic [ID_W-1:0] s, logic [ID_W-1:0] t, bit tag);
    logic [ID_W-1:0] mn, mx, cmp, msk;
    bit ok;
    mn = tw[11:1]; mx = tw[22:12]; cmp = sw[11:1]; msk = sw[22:12];
    if (!c[1]) return 1'b1;
    ok = 1'b1;
    if (c[5] && !(mx != 0 && mx >= mn && t >= mn && t <= mx)) ok = 1'b0;
    if (c[4] && (((s ^ cmp) & ~msk) != 0)) ok = 1'b0;
    if (c[2] && !tag) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one transaction, check the result one cycle later
  task automatic send(string req, logic [31:0] c, logic [31:0] sw, logic [31:0] tw,
                      logic [ID_W-1:0] s, logic [ID_W-1:0] t, bit tag, bit v);
    bit exp;
    ctrl_word = c; srcid_word = sw; tgtid_word = tw;
    txn_src = s; txn_tgt = t; txn_tag = tag; txn_valid = v;
    exp = v && model(c, sw, tw, s, t, tag);
    @(posedge clk); #1;
    check({req, " R8 valid"}, q_valid, v);
    check(req, q_count, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] w_win, w_src;
    void'($urandom(32'd1234));
    txn_valid = 1'b1; ctrl_word = mk_ctl(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", q_valid, 1'b0);
    check("R1 reset count", q_count, 1'b0);
    txn_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle valid", q_valid, 1'b0);
    check("R1 first cycle count", q_count, 1'b0);

    // R2: master off ignores everything
    send("R2", mk_ctl(0, 1, 1, 1), mk_pair(11'h7, 11'h0), mk_pair(11'h10, 11'h0), 11'h3, 11'h500, 0, 1);
    // R9: master on, nothing enabled, zero words
    send("R9", mk_ctl(1, 0, 0, 0), 32'h0, 32'h0, 11'h7ff, 11'h7ff, 0, 1);
    // R3 window edges
    w_win = mk_pair(11'd100, 11'd200);
    send("R3 at min",  mk_ctl(1, 0, 0, 1), 0, w_win, 0, 11'd100, 0, 1);
    send("R3 at max",  mk_ctl(1, 0, 0, 1), 0, w_win, 0, 11'd200, 0, 1);
    send("R3 below",   mk_ctl(1, 0, 0, 1), 0, w_win, 0, 11'd99,  0, 1);
    send("R3 above",   mk_ctl(1, 0, 0, 1), 0, w_win, 0, 11'd201, 0, 1);
    send("R3 min=max", mk_ctl(1, 0, 0, 1), 0, mk_pair(11'd5, 11'd5), 0, 11'd5, 0, 1);
    // R4 invalid windows
    send("R4 max zero", mk_ctl(1, 0, 0, 1), 0, mk_pair(11'd0, 11'd0), 0, 11'd0, 0, 1);
    send("R4 max<min",  mk_ctl(1, 0, 0, 1), 0, mk_pair(11'd50, 11'd40), 0, 11'd45, 0, 1);
    // R5 source mask
    w_src = mk_pair(11'h0a5, 11'h00f);
    send("R5 exact",    mk_ctl(1, 0, 1, 0), w_src, 0, 11'h0a5, 0, 0, 1);
    send("R5 masked",   mk_ctl(1, 0, 1, 0), w_src, 0, 11'h0aa, 0, 0, 1);
    send("R5 unmasked", mk_ctl(1, 0, 1, 0), w_src, 0, 11'h1a5, 0, 0, 1);
    // R6 trace tag
    send("R6 tag0", mk_ctl(1, 1, 0, 0), 0, 0, 0, 0, 0, 1);
    send("R6 tag1", mk_ctl(1, 1, 0, 0), 0, 0, 0, 0, 1, 1);
    // R7 combination: disabled failing check does not veto
    send("R7 disabled veto", mk_ctl(1, 1, 0, 0), w_src, mk_pair(11'd0, 11'd0), 11'h1a5, 11'd9, 1, 1);
    send("R7 one fails",     mk_ctl(1, 1, 1, 1), w_src, w_win, 11'h0a5, 11'd150, 0, 1);
    send("R7 all pass",      mk_ctl(1, 1, 1, 1), w_src, w_win, 11'h0a5, 11'd150, 1, 1);
    // R8 no transaction
    send("R8 idle", mk_ctl(0, 0, 0, 0), 0, 0, 0, 0, 1, 0);

    for (int i = 0; i < 400; i++) begin
      logic [ID_W-1:0] a, b, s, t;
      logic [31:0] c, sw;
      a = ID_W'($urandom_range(0, 300));
      b = ID_W'($urandom_range(0, 300));
      c = $urandom() & 32'h36;
      sw = mk_pair(ID_W'($urandom()), ID_W'($urandom() & 32'h0f0));
      s = ($urandom_range(0, 1) == 1) ? sw[11:1] ^ ID_W'($urandom() & 32'h0f0) : ID_W'($urandom());
      t = ID_W'($urandom_range(0, 310));
      send("R7 random", c, sw, mk_pair(a, b), s, t, 1'($urandom()), 1'($urandom_range(0, 7) != 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule